// File: doc/BRIEF.md
# Flag Offset and Control Register Loader

This block holds the three programmable words that steer a FIFO's status flags: the almost-empty offset, the almost-full offset and a small flag-control word. Software and neighbouring logic reach them through the FIFO's own data paths rather than through a register bus. When the load select input `ld` is high, an enabled write cycle stores the low bits of `wr_data` into the register picked by a write pointer. An enabled read cycle returns a register on `rd_data`, picked by a separate read pointer. Each pointer steps to the next register after every accepted cycle. While `ld` is high, the enables sent on to the FIFO memory are held low, so the memory pointers and contents stay untouched.

Both ports share one clock, and the reset is synchronous. The `emode_n` strap is sampled on every reset edge and picks the mode until the next reset. When it is low the block runs in enhanced mode: the control word takes part in the loading order, and its reset value is all ones. When it is high the block runs in compatible mode: the control word stays all zeros, and the pointers skip it. The offsets reset to one eighth of the FIFO depth minus one, which is 63 for a 512-word FIFO and 127 for a 1024-word FIFO. Programming is optional, and the words can be reloaded at any time without another reset.

Each pointer is a three-state machine with the states SEL_AE, SEL_AF and SEL_CTL. Reset puts it in SEL_AE. An accepted cycle moves SEL_AE to SEL_AF. From SEL_AF it moves to SEL_CTL in enhanced mode, or back to SEL_AE in compatible mode. From SEL_CTL it always returns to SEL_AE. With no accepted cycle, the pointer keeps its state.

Top module: `flag_offset_loader`

## Requirements
- R1: After reset, `ae_offset` and `af_offset` both equal 2^DEPTH_LOG2/8 - 1, which is 63 with the default DEPTH_LOG2 of 9.
- R2: If `emode_n` is 0 at a reset edge, then `enh_mode` is 1 and `flag_ctrl` is all ones after reset. If `emode_n` is 1, then `enh_mode` is 0 and `flag_ctrl` is 0.
- R3: On a clock edge with `ld`=1 and `wr_en`=1, the register selected by the write pointer takes `wr_data[OW-1:0]` (an offset) or `wr_data[CW-1:0]` (the control word), and the write pointer advances.
- R4: On an accepted read edge, `rd_data` takes the register selected by the read pointer, zero-extended, and the read pointer advances. The read pointer is independent of the write pointer.
- R5: Pointer order is almost-empty, then almost-full, then control, then back to almost-empty. Compatible mode leaves out the control step.
- R6: A read (`ld`=1 with `rd_en`=1) is ignored if `wr_en` is 1 in the same cycle, or if a load write has already happened since `ld` last went low. An ignored read leaves `rd_data` and the read pointer unchanged.
- R7: While `ld` is 1, `mem_wr_en` and `mem_rd_en` are 0. While `ld` is 0, they follow `wr_en` and `rd_en`.
- R8: A register changes only on a load write that selects it. Later load writes replace values without a reset.
- R9: Reset returns both pointers to the almost-empty register.
- R10: In compatible mode `flag_ctrl` stays 0, and `enh_mode` holds its value between resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| emode_n | input | 1 | Mode strap sampled during reset, low selects enhanced mode |
| ld | input | 1 | Load select: sends the enables to the registers |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data bus |
| rd_en | input | 1 | Read enable |
| rd_data | output | DW | Register read-back data |
| mem_wr_en | output | 1 | Write enable passed to the FIFO memory |
| mem_rd_en | output | 1 | Read enable passed to the FIFO memory |
| ae_offset | output | OW | Almost-empty offset |
| af_offset | output | OW | Almost-full offset |
| flag_ctrl | output | CW | Flag control word |
| enh_mode | output | 1 | Enhanced mode latched at reset |

## Verification
The bench goes after three kinds of error: a pointer that wraps at the wrong place, a read that slips through during a load-write session, and a strap that is sampled outside reset. A design that wraps wrongly puts a third compatible-mode write into a control word that cannot be seen, or skips the control word in enhanced mode. A design that lets such a read through shows a changed `rd_data` and then returns the next register out of order. The bench also drops `ld` between sessions to show that reads are allowed again. It resets repeatedly with either strap value, and it checks that reloading replaces earlier values.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    typedef enum logic [1:0] {
        SEL_AE  = 2'd0,
        SEL_AF  = 2'd1,
        SEL_CTL = 2'd2
    } sel_e;
endpackage

// File: rtl/ldr_ptr_fsm.sv
module ldr_ptr_fsm
    import ldr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enh,
    input  logic adv,
    output sel_e sel
);
    sel_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_AE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                SEL_AE:  state_d = SEL_AF;
                SEL_AF:  state_d = enh ? SEL_CTL : SEL_AE;
                SEL_CTL: state_d = SEL_AE;
                default: state_d = SEL_AE;
            endcase
        end
    end

    assign sel = state_q;
endmodule

// File: rtl/ldr_regfile.sv
module ldr_regfile
    import ldr_pkg::*;
#(
    parameter int OW = 9,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enh_init,
    input  logic          we,
    input  sel_e          sel,
    input  logic [OW-1:0] wdata,
    output logic [OW-1:0] ae_q,
    output logic [OW-1:0] af_q,
    output logic [CW-1:0] ctl_q
);
    localparam logic [OW-1:0] DEF_OFS = OW'((2 ** OW) / 8 - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_q  <= DEF_OFS;
            af_q  <= DEF_OFS;
            ctl_q <= enh_init ? '1 : '0;
        end else if (we) begin
            unique case (sel)
                SEL_AE:  ae_q  <= wdata;
                SEL_AF:  af_q  <= wdata;
                SEL_CTL: ctl_q <= wdata[CW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import ldr_pkg::*;
#(
    parameter int DW         = 18,
    parameter int DEPTH_LOG2 = 9,
    parameter int CW         = 6,
    localparam int OW        = DEPTH_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          emode_n,
    input  logic          ld,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          mem_wr_en,
    output logic          mem_rd_en,
    output logic [OW-1:0] ae_offset,
    output logic [OW-1:0] af_offset,
    output logic [CW-1:0] flag_ctrl,
    output logic          enh_mode
);
    logic    enh_q, wseq_q, ld_wr, ld_rd;
    sel_e    wsel, rsel;
    logic [DW-1:0] rd_q, rd_mux;

    assign ld_wr     = ld & wr_en;
    assign ld_rd     = ld & rd_en & ~wr_en & ~wseq_q;
    assign mem_wr_en = wr_en & ~ld;
    assign mem_rd_en = rd_en & ~ld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enh_q  <= ~emode_n;
            wseq_q <= 1'b0;
            rd_q   <= '0;
        end else begin
            if (!ld)        wseq_q <= 1'b0;
            else if (wr_en) wseq_q <= 1'b1;
            if (ld_rd)      rd_q   <= rd_mux;
        end
    end

    ldr_ptr_fsm u_wptr (.clk(clk), .rst_n(rst_n), .enh(enh_q), .adv(ld_wr), .sel(wsel));
    ldr_ptr_fsm u_rptr (.clk(clk), .rst_n(rst_n), .enh(enh_q), .adv(ld_rd), .sel(rsel));

    ldr_regfile #(.OW(OW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .enh_init(~emode_n), .we(ld_wr), .sel(wsel),
        .wdata(wr_data[OW-1:0]), .ae_q(ae_offset), .af_q(af_offset), .ctl_q(flag_ctrl)
    );

    always_comb begin
        unique case (rsel)
            SEL_AE:  rd_mux = DW'(ae_offset);
            SEL_AF:  rd_mux = DW'(af_offset);
            SEL_CTL: rd_mux = DW'(flag_ctrl);
            default: rd_mux = '0;
        endcase
    end

    generate
        if (DW > OW) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wr_data[DW-1:OW];
        end
    endgenerate

    assign rd_data  = rd_q;
    assign enh_mode = enh_q;
endmodule

// File: rtl/ldr_chk.sv
module ldr_chk #(
    parameter int DW = 18,
    parameter int OW = 9,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [OW-1:0] ae_offset,
    input logic [CW-1:0] flag_ctrl,
    input logic          enh_mode
);
    AST_AE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld && wr_en) |=> $stable(ae_offset)); // R8
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && rd_en && wr_en) |=> $stable(rd_data)); // R6
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(rd_data)); // R4
    AST_COMPAT_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode |-> (flag_ctrl == '0)); // R10
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(enh_mode)); // R10
endmodule

bind flag_offset_loader ldr_chk #(.DW(DW), .OW(OW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld(ld), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .ae_offset(ae_offset), .flag_ctrl(flag_ctrl), .enh_mode(enh_mode)
);

// File: tb/sim_flag_offset_loader.sv
`timescale 1ns/1ps
module sim_flag_offset_loader;
    localparam int DW = 18, OW = 9, CW = 6;
    localparam logic [OW-1:0] DEF = 63;

    logic clk = 0, rst_n = 0, emode_n = 1, ld = 0, wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic mem_wr_en, mem_rd_en, enh_mode;
    logic [OW-1:0] ae_offset, af_offset;
    logic [CW-1:0] flag_ctrl;

    int total = 0, bad = 0;
    logic done = 0;

    // model state
    logic m_enh, m_wseq;
    logic [OW-1:0] m_ae, m_af;
    logic [CW-1:0] m_ctl;
    logic [DW-1:0] m_rd;
    int m_wp, m_rp;

    always #2 clk = ~clk;

    flag_offset_loader u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int p, input logic enh);
        return (p == 0) ? 1 : (p == 1) ? (enh ? 2 : 0) : 0;
    endfunction

    function automatic logic [DW-1:0] regval(input int p);
        return (p == 0) ? DW'(m_ae) : (p == 1) ? DW'(m_af) : DW'(m_ctl);
    endfunction

    task automatic cyc(input logic r, input logic e, input logic l, input logic w,
                       input logic [DW-1:0] d, input logic rr);
        logic wacc, racc;
        rst_n = r; emode_n = e; ld = l; wr_en = w; wr_data = d; rd_en = rr;
        #1;
        if (r) begin
            chk("R7 mem_wr_en", mem_wr_en, w & ~l);
            chk("R7 mem_rd_en", mem_rd_en, rr & ~l);
        end
        @(posedge clk);
        if (!r) begin
            m_enh = ~e; m_ctl = m_enh ? '1 : '0; m_ae = DEF; m_af = DEF;
            m_wp = 0; m_rp = 0; m_rd = '0; m_wseq = 0;
        end else begin
            wacc = l & w;
            racc = l & rr & ~w & ~m_wseq;
            if (racc) begin m_rd = regval(m_rp); m_rp = nxt(m_rp, m_enh); end
            if (wacc) begin
                if (m_wp == 0) m_ae = d[OW-1:0];
                else if (m_wp == 1) m_af = d[OW-1:0];
                else m_ctl = d[CW-1:0];
                m_wp = nxt(m_wp, m_enh);
            end
            m_wseq = l ? (m_wseq | w) : 1'b0;
        end
        @(negedge clk);
        chk("R3 R8 ae_offset", ae_offset, m_ae);
        chk("R3 R8 af_offset", af_offset, m_af);
        chk("R2 R10 flag_ctrl", flag_ctrl, m_ctl);
        chk("R2 R10 enh_mode", enh_mode, m_enh);
        chk("R4 R6 rd_data", rd_data, m_rd);
    endtask

    task automatic do_reset(input logic e);
        cyc(0, e, 0, 0, '0, 0);
        cyc(0, e, 0, 0, '0, 0);
        chk("R1 ae default", ae_offset, 63);
        chk("R1 af default", af_offset, 63);
        chk("R2 ctrl default", flag_ctrl, e ? 0 : 6'h3F);
    endtask

    initial begin
        @(negedge clk);
        // compatible mode: third write wraps to almost-empty (R5, R9)
        do_reset(1);
        cyc(1, 1, 1, 1, 18'h00011, 0);
        cyc(1, 1, 1, 1, 18'h00022, 0);
        cyc(1, 1, 1, 1, 18'h3FF33, 0);
        chk("R5 compat wrap", ae_offset, 9'h133);
        chk("R9 compat ctrl untouched", flag_ctrl, 0);
        cyc(1, 1, 1, 0, '0, 1);    // blocked: session still open
        chk("R6 blocked read", rd_data, 0);
        cyc(1, 1, 0, 0, '0, 0);    // session ends
        cyc(1, 1, 1, 0, '0, 1);
        chk("R4 R9 first read from AE", rd_data, 18'h133);
        // enhanced mode: control in order, same-cycle write blocks read
        do_reset(0);
        cyc(1, 0, 1, 0, '0, 1);
        chk("R9 R4 read after reset", rd_data, 63);
        cyc(1, 0, 1, 1, 18'h00005, 1);
        cyc(1, 0, 1, 1, 18'h00006, 0);
        cyc(1, 0, 1, 1, 18'h0002A, 0);
        chk("R5 ctrl step", flag_ctrl, 6'h2A);
        cyc(1, 0, 0, 1, 18'h0, 1);
        chk("R7 unloaded cycle keeps ae", ae_offset, 5);
        cyc(1, 1, 1, 0, '0, 1);    // strap change outside reset ignored
        chk("R10 mode kept", enh_mode, 1);
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] p;
            p = 7'($urandom % 100);
            if (p == 0) do_reset(1'($urandom));
            else cyc(1, 1'($urandom), ($urandom % 10) < 7, ($urandom % 10) < 4,
                     DW'($urandom), ($urandom % 10) < 4);
        end
        done = 1;
    end

    initial begin
        void'($urandom(32'd1234));
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule